// File: doc/BRIEF.md
# MRU-Bit Pseudo-LRU Replacement Controller

This block holds the replacement state for a set-associative cache and picks the way to evict on a miss. Each set keeps one recency flag per way. The cache's lookup logic reports every touch of a way, whether a hit or the fill that follows a miss. The block sets that way's flag. If setting it would leave the set with no clear flags, every other flag in that set is wiped, so that only the touched way stays marked.

On a miss, the cache presents the set index on the query port. The block returns the lowest-numbered way whose flag is clear. It finds that way with a combinational priority scan of the stored flags, so the answer is ready in the same cycle. This approximates least-recently-used order with one bit per way. It does not guarantee that the true oldest line is chosen. A way touched recently can still be picked, as long as it is the lowest clear index.

Tags, data, hit detection and refill belong to the surrounding cache. The number of ways and the number of sets are parameters.

Top module: `mru_repl_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, every flag of every set is clear, so a query on any set returns way 0.
- R2: An update with `upd_valid` high sets the flag of way `upd_way` in set `upd_set`. From the next cycle on, a query of that set never returns that way.
- R3: When an update would leave all flags of its set marked, only the updated way's flag stays set and the others are cleared. A set therefore never holds all flags marked.
- R4: `victim_way` is the binary index of the lowest-numbered way whose flag is clear in set `qry_set`. Every lower-numbered way in that set has its flag set.
- R5: An update changes the state at the next rising clock edge. A query made in the same cycle as an update to the same set returns the result for the state before that update.
- R6: An update to one set leaves the flags of every other set unchanged.
- R7: While `upd_valid` is low, `upd_set` and `upd_way` have no effect on any stored flag.
- R8: Updating a way whose flag is already set, while other ways of the set are still clear, leaves the set unchanged.
- R9: `NUM_WAYS` must be a power of two and at least 2. Way indices are carried in binary on log2(`NUM_WAYS`) bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all flags |
| upd_valid | input | 1 | Qualifies an access report for this cycle |
| upd_set | input | log2(NUM_SETS) | Set index of the accessed line |
| upd_way | input | log2(NUM_WAYS) | Way index of the accessed line |
| qry_set | input | log2(NUM_SETS) | Set index for which a victim is wanted |
| victim_way | output | log2(NUM_WAYS) | Lowest way of `qry_set` whose flag is clear |

## Verification
The hardest situation to reach is the wrap, where the last clear flag of a set gets marked. The wipe of the other flags only shows at the ports indirectly, through which way the next query picks. The stimulus reaches it in two ways. First, directed sequences mark every way of a set in several different orders. Second, a long pseudo-random walk uses a small configuration (four ways, four sets) and restricts the random way index so that each set fills and wraps many times, with queries often aimed at the set being updated in that same cycle. A bench model built from the requirements predicts the victim on every cycle. It computes the lowest clear flag arithmetically, as the isolated bit of `~row & (row + 1)`.

// File: rtl/mru_repl_pkg.sv
package mru_repl_pkg;

    // Classification of what an access report does to a set's flags
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,   // no report this cycle
        UPD_MARK = 2'd1,   // flag set, other flags kept
        UPD_WRAP = 2'd2    // last clear flag marked, others wiped
    } upd_kind_e;

    // Elaboration-time configuration helper
    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

    // Width of an index able to address n items (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mru_row_next.sv
module mru_row_next
    import mru_repl_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned WAY_W   = idx_width(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] row_i,
    input  logic                hit_en_i,
    input  logic [WAY_W-1:0]    way_i,
    output logic [NUM_WAYS-1:0] row_o,
    output upd_kind_e           kind_o
);

    logic [NUM_WAYS-1:0] way_onehot;
    logic [NUM_WAYS-1:0] merged;

    assign way_onehot = NUM_WAYS'(1) << way_i;
    assign merged     = row_i | way_onehot;

    always_comb begin
        if (!hit_en_i) begin
            row_o  = row_i;
            kind_o = UPD_NONE;
        end else if (&merged) begin
            row_o  = way_onehot;
            kind_o = UPD_WRAP;
        end else begin
            row_o  = merged;
            kind_o = UPD_MARK;
        end
    end

endmodule

// File: rtl/mru_victim_pick.sv
module mru_victim_pick
    import mru_repl_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned WAY_W   = idx_width(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] row_i,
    output logic [WAY_W-1:0]    victim_o
);

    // Scan from the top down so the lowest clear index is written last
    always_comb begin
        victim_o = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!row_i[i]) begin
                victim_o = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/mru_state_bank.sv
module mru_state_bank
    import mru_repl_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned SET_W   = idx_width(NUM_SETS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [SET_W-1:0]                  wr_set,
    input  logic [NUM_WAYS-1:0]               wr_row,
    output logic [NUM_SETS-1:0][NUM_WAYS-1:0] rows_o
);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [NUM_WAYS-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (wr_en && (wr_set == SET_W'(s))) begin
                row_q <= wr_row;
            end
        end

        assign rows_o[s] = row_q;
    end

endmodule

// File: rtl/mru_repl_ctrl.sv
module mru_repl_ctrl
    import mru_repl_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned WAY_W   = idx_width(NUM_WAYS),
    localparam int unsigned SET_W   = idx_width(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAY_W-1:0] victim_way
);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0] state_q;
    logic [NUM_WAYS-1:0]               upd_row_cur;
    logic [NUM_WAYS-1:0]               upd_row_nxt;
    logic [NUM_WAYS-1:0]               qry_row;
    upd_kind_e                         upd_kind;

    assign upd_row_cur = state_q[upd_set];
    assign qry_row     = state_q[qry_set];

    mru_row_next #(.NUM_WAYS(NUM_WAYS)) u_next (
        .row_i    (upd_row_cur),
        .hit_en_i (upd_valid),
        .way_i    (upd_way),
        .row_o    (upd_row_nxt),
        .kind_o   (upd_kind)
    );

    mru_state_bank #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (upd_valid),
        .wr_set (upd_set),
        .wr_row (upd_row_nxt),
        .rows_o (state_q)
    );

    mru_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .row_i    (qry_row),
        .victim_o (victim_way)
    );

endmodule

// File: rtl/mru_repl_chk.sv
module mru_repl_chk
    import mru_repl_pkg::*;
#(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned WAY_W   = idx_width(NUM_WAYS),
    localparam int unsigned SET_W   = idx_width(NUM_SETS)
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              upd_valid,
    input logic [SET_W-1:0]                  upd_set,
    input logic [WAY_W-1:0]                  upd_way,
    input logic [SET_W-1:0]                  qry_set,
    input logic [WAY_W-1:0]                  victim_way,
    input upd_kind_e                         upd_kind,
    input logic [NUM_SETS-1:0][NUM_WAYS-1:0] state_q
);

    logic [NUM_WAYS-1:0] q_row;
    logic [NUM_WAYS-1:0] below_mask;

    assign q_row      = state_q[qry_set];
    assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

    initial begin
        AST_CFG_WAYS: assert (is_pow2(NUM_WAYS) && NUM_WAYS >= 2 && WAY_W == $clog2(NUM_WAYS)); // R9
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (state_q == '0)); // R1

    AST_MARKED_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ((qry_set != $past(upd_set)) || (victim_way != $past(upd_way)))); // R2

    AST_WRAP_ONE_LEFT: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_kind == UPD_WRAP) |=> ($countones(state_q[$past(upd_set)]) == 1)); // R3

    AST_ROW_HAS_ZERO: assert property (@(posedge clk) disable iff (rst)
        q_row != {NUM_WAYS{1'b1}}); // R3

    AST_VICTIM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !q_row[victim_way]); // R4

    AST_VICTIM_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (q_row & below_mask) == below_mask); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(state_q)); // R7

endmodule

bind mru_repl_ctrl mru_repl_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_valid  (upd_valid),
    .upd_set    (upd_set),
    .upd_way    (upd_way),
    .qry_set    (qry_set),
    .victim_way (victim_way),
    .upd_kind   (upd_kind),
    .state_q    (state_q)
);

// File: tb/tb_mru_repl_ctrl.sv
module tb_mru_repl_ctrl;

    localparam int WAYS  = 4;
    localparam int SETS  = 4;
    localparam int WAY_W = 2;
    localparam int SET_W = 2;
    localparam int WATCHDOG_CYCLES = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_valid = 1'b0;
    logic [SET_W-1:0] upd_set = '0;
    logic [WAY_W-1:0] upd_way = '0;
    logic [SET_W-1:0] qry_set = '0;
    logic [WAY_W-1:0] victim_way;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    int unsigned cycles  = 0;
    bit          done    = 1'b0;

    logic [WAYS-1:0] model [SETS];
    logic [15:0]     lfsr = 16'hACE1;

    always #10 clk = ~clk; // 50 MHz

    mru_repl_ctrl #(.NUM_WAYS(WAYS), .NUM_SETS(SETS)) dut (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .qry_set    (qry_set),
        .victim_way (victim_way)
    );

    // Lowest clear flag: isolate the bit ~row & (row+1), then take its log2
    function automatic int exp_victim(input logic [WAYS-1:0] row);
        logic [WAYS-1:0] iso;
        iso = ~row & (row + WAYS'(1));
        return $clog2(int'(iso));
    endfunction

    function automatic logic [WAYS-1:0] model_next(input logic [WAYS-1:0] row, input int w);
        logic [WAYS-1:0] bit_w;
        bit_w = WAYS'(1) << w;
        if ((row | bit_w) == {WAYS{1'b1}}) return bit_w;
        return row | bit_w;
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    // One cycle: drive at negedge, compare pre-update victim, apply edge
    task automatic step(input bit v, input int s, input int w, input int q, input string tag);
        @(negedge clk);
        upd_valid = v;
        upd_set   = SET_W'(s);
        upd_way   = WAY_W'(w);
        qry_set   = SET_W'(q);
        #1;
        check(tag, int'(victim_way), exp_victim(model[q]));
        @(posedge clk);
        if (v) model[s] = model_next(model[s], w);
    endtask

    task automatic query(input int q, input int expected, input string tag);
        @(negedge clk);
        upd_valid = 1'b0;
        qry_set   = SET_W'(q);
        #1;
        check(tag, int'(victim_way), expected);
        check({tag, " model"}, exp_victim(model[q]), expected);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SETS; s++) model[s] = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG_CYCLES) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
                finish_run();
            end
        end
    end

    initial begin
        // R9: way index carried on log2(WAYS) bits
        check("R9 victim width", $bits(victim_way), WAY_W);

        // R1: reset clears every set
        do_reset();
        for (int s = 0; s < SETS; s++) query(s, 0, "R1 after reset");

        // R2: marking way 0 of a fresh set moves the victim to way 1
        step(1'b1, 0, 0, 0, "R2 pre");
        query(0, 1, "R2 marked way skipped");

        // R6: set 0 activity left set 1 untouched
        query(1, 0, "R6 other set unchanged");

        // R4/R5: build 0,1,1,0 in set 2, then hit way 0 with same-cycle query
        step(1'b1, 2, 1, 2, "R4 build");
        step(1'b1, 2, 2, 2, "R4 build");
        query(2, 0, "R4 lowest clear is way 0");
        step(1'b1, 2, 0, 2, "R5 same-cycle query sees old state");
        query(2, 3, "R4 only way 3 clear");

        // R8: re-marking a set way while others clear changes nothing
        step(1'b1, 2, 1, 2, "R8 pre");
        query(2, 3, "R8 re-mark no change");

        // R7: invalid report to set 2 way 3 must not wrap the set
        step(1'b0, 2, 3, 2, "R7 pre");
        query(2, 3, "R7 invalid report ignored");

        // R3: filling way 3 wraps, leaving 0,0,0,1
        step(1'b1, 2, 3, 2, "R3 fill");
        query(2, 0, "R3 wrap clears others");
        step(1'b1, 2, 0, 2, "R3 after wrap");
        query(2, 1, "R3 only way 3 and 0 marked");
        step(1'b1, 2, 1, 2, "R3 pre");
        query(2, 2, "R3 way 2 clear");

        // R3 in descending order: 3,2,1 then 0 wraps to way 0 only
        step(1'b1, 3, 3, 3, "R3 desc");
        step(1'b1, 3, 2, 3, "R3 desc");
        step(1'b1, 3, 1, 3, "R3 desc");
        query(3, 0, "R3 desc before wrap");
        step(1'b1, 3, 0, 3, "R3 desc wrap");
        query(3, 1, "R3 desc after wrap");

        // R4/R5/R6/R7/R8 random walk with model comparison every cycle
        for (int n = 0; n < 6000; n++) begin
            bit v;
            int s, w, q;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = (lfsr[2:0] != 3'd0);
            s = int'(lfsr[4:3]);
            w = int'(lfsr[6:5]);
            q = lfsr[7] ? s : int'(lfsr[9:8]);
            step(v, s, w, q, "R4 random walk");
        end
        for (int s = 0; s < SETS; s++) query(s, exp_victim(model[s]), "R6 final per-set state");

        // R1: reset mid-run clears everything again
        do_reset();
        for (int s = 0; s < SETS; s++) query(s, 0, "R1 reset mid-run");

        finish_run();
    end

endmodule